// File: doc/BRIEF.md
# Pipelined Store Write Stage

This block is the store and load datapath of a direct-mapped data cache. It is built so that a store's tag compare and its data-array write never sit in the same clock cycle. A store that hits the tags is not written at once. Its word address, data and byte enables are kept in a single parked-write register. The parked entry goes into the data array during the cycle of the next store, while that store does its own tag compare. The single-port data array is therefore addressed by the parked entry on store cycles and by the incoming address on load cycles.

A load whose word address equals the parked entry takes the parked bytes from the register. It takes every other byte from the array, so a load never sees stale data. Misses are reported through `rsp_hit` and resolved by the requester: it supplies the line on the fill port and issues the request again. A fill to the line index that the parked entry targets is held back for one cycle. During that cycle the parked entry is drained into the array and then dropped, so it can never land on top of the newly filled line.

Top module: `csw_store_stage`

## Requirements
- R1: After reset every line is invalid, `rsp_valid` is 0 and, with no request present, `fill_ready` is 1. A load issued before any fill reports `rsp_hit` = 0.
- R2: A request accepted at a rising edge produces `rsp_valid` = 1 at the next edge, and `rsp_valid` is 0 in any cycle after a cycle without a request. A load that hits returns the stored word on `rsp_rdata` in that response.
- R3: A store that hits (`rsp_hit` = 1) makes its enabled bytes visible to every later load of the same word address.
- R4: A store that misses writes nothing, and the parked write already held survives it. A later load of the parked address still returns the parked data.
- R5: The data array is never written in a load cycle. A parked store reaches the array during the next store's cycle, so a load of the earlier store's address returns correct data from the array once a different store has replaced it in the register.
- R6: A load that matches the parked word address returns the parked bytes where the parked byte enable (bit b for bits 8b+7..8b) is set, and array bytes elsewhere.
- R7: A load with the same line index but a different tag from the parked entry and the resident line misses and takes nothing from the parked register.
- R8: When a fill targets the line index of a valid parked entry, `fill_ready` stays 0 for exactly one cycle while the entry drains. After the fill, later stores to other lines never alter the filled word.
- R9: A load that misses reports `rsp_hit` = 0. After a fill of that address with word W, the same load hits and returns W.
- R10: Two hitting stores to the same word, one after another, leave the second store's data in effect.
- R11: Under random mixes of loads and stores over colliding addresses, every load hit equals the contents of a flat reference memory.
- R12: `fill_ready` is 0 in any cycle in which `req_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address: tag, line index, byte offset |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Tag matched for that request |
| rsp_rdata | output | DATA_W | Load data, merged with parked bytes |
| fill_valid | input | 1 | Fill word offered |
| fill_addr | input | ADDR_W | Address of the line being filled |
| fill_data | input | DATA_W | Line contents |
| fill_ready | output | 1 | Fill taken at this edge when fill_valid is 1 |

## Verification
Two functions share every store cycle: the new store's tag compare and the array write of the previously parked store. The bench provokes this with stores to different lines followed by a load of the first address. That load misses the register, so its data can only have come from the array write made during the second store. Load bypass and a pending write also coincide: a partial store followed at once by a load of the same word must return a byte-by-byte merge of the register and the array. Fill drain is provoked by filling a different tag into a parked line's index, and is judged by the one-cycle stall and by the filled word staying intact after a later store.

// File: rtl/csw_pkg.sv
package csw_pkg;
  // Source that owns the single data-array port in a cycle
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_LOAD = 2'd1,
    SRC_PARK = 2'd2,
    SRC_FILL = 2'd3
  } port_src_e;
endpackage

// File: rtl/csw_tag_store.sv
module csw_tag_store #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] line_ok;
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_ok <= '0;
    end else if (wr_en) begin
      line_ok[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
    end
  end

  assign lk_hit = line_ok[lk_idx] && (tag_mem[lk_idx] == lk_tag);

  // A line only becomes valid through a write
  AST_VALID_ONLY_BY_FILL: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($countones(line_ok) == $countones($past(line_ok)))); // R1
endmodule

// File: rtl/csw_data_ram.sv
module csw_data_ram #(
  parameter int DEPTH_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic                  we,
  input  logic [DATA_W/8-1:0]   be,
  input  logic [DEPTH_W-1:0]    addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);
  localparam int BYTES = DATA_W / 8;
  localparam int DEPTH = 1 << DEPTH_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (we && be[b]) begin
          mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
        end
      end
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/csw_park_buf.sv
module csw_park_buf #(
  parameter int WORD_W = 14,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cap_en,
  input  logic [WORD_W-1:0]     cap_word,
  input  logic [DATA_W-1:0]     cap_data,
  input  logic [DATA_W/8-1:0]   cap_be,
  input  logic                  drain,
  output logic                  p_valid,
  output logic [WORD_W-1:0]     p_word,
  output logic [DATA_W-1:0]     p_data,
  output logic [DATA_W/8-1:0]   p_be,
  input  logic                  lk_en,
  input  logic [WORD_W-1:0]     lk_word,
  output logic [DATA_W/8-1:0]   byp_mask,
  output logic [DATA_W-1:0]     byp_data
);
  localparam int BYTES = DATA_W / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
    end else if (cap_en) begin
      p_valid <= 1'b1;
    end else if (drain) begin
      p_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      p_word <= cap_word;
      p_data <= cap_data;
      p_be   <= cap_be;
    end
  end

  // Bypass decision taken in the load cycle, used with the array output next cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_mask <= '0;
    end else if (lk_en && p_valid && (p_word == lk_word)) begin
      byp_mask <= p_be;
    end else begin
      byp_mask <= {BYTES{1'b0}};
    end
    byp_data <= p_data;
  end

  AST_PARK_HELD: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !drain) |=> ($stable(p_word) && $stable(p_data) && $stable(p_valid))); // R4
endmodule

// File: rtl/csw_store_stage.sv
module csw_store_stage #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [DATA_W-1:0]     rsp_rdata,
  input  logic                  fill_valid,
  input  logic [ADDR_W-1:0]     fill_addr,
  input  logic [DATA_W-1:0]     fill_data,
  output logic                  fill_ready
);
  import csw_pkg::*;

  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int WORD_W = ADDR_W - OFF_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W;

  logic [WORD_W-1:0]  req_word;
  logic [INDEX_W-1:0] req_idx, fill_idx, park_idx;
  logic [TAG_W-1:0]   req_tag, fill_tag;

  assign req_word = req_addr[ADDR_W-1:OFF_W];
  assign req_idx  = req_addr[OFF_W +: INDEX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign fill_idx = fill_addr[OFF_W +: INDEX_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

  logic load_cyc, store_cyc;
  assign load_cyc  = req_valid && !req_store;
  assign store_cyc = req_valid && req_store;

  // Tag lookup
  logic lk_hit, fill_acc;
  csw_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst    (rst),
    .lk_idx (req_idx),
    .lk_tag (req_tag),
    .lk_hit (lk_hit),
    .wr_en  (fill_acc),
    .wr_idx (fill_idx),
    .wr_tag (fill_tag)
  );

  // Parked write register
  logic               park_valid;
  logic [WORD_W-1:0]  park_word;
  logic [DATA_W-1:0]  park_data;
  logic [BYTES-1:0]   park_be;
  logic [BYTES-1:0]   byp_mask;
  logic [DATA_W-1:0]  byp_data;
  logic               drain;

  csw_park_buf #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_park (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (store_cyc && lk_hit),
    .cap_word (req_word),
    .cap_data (req_wdata),
    .cap_be   (req_be),
    .drain    (drain),
    .p_valid  (park_valid),
    .p_word   (park_word),
    .p_data   (park_data),
    .p_be     (park_be),
    .lk_en    (load_cyc),
    .lk_word  (req_word),
    .byp_mask (byp_mask),
    .byp_data (byp_data)
  );

  assign park_idx = park_word[INDEX_W-1:0];

  // Fill admission: CPU requests own the port; a parked write to the
  // same line drains first
  logic fill_hazard;
  assign fill_hazard = park_valid && (park_idx == fill_idx);
  assign fill_ready  = !req_valid && !fill_hazard;
  assign fill_acc    = fill_valid && fill_ready;
  assign drain       = fill_valid && !req_valid && fill_hazard;

  // Single data-array port
  port_src_e          src;
  logic               ram_en, ram_we;
  logic [BYTES-1:0]   ram_be;
  logic [INDEX_W-1:0] ram_addr;
  logic [DATA_W-1:0]  ram_wdata, ram_rdata;

  always_comb begin
    if (load_cyc)                                src = SRC_LOAD;
    else if ((store_cyc && park_valid) || drain) src = SRC_PARK;
    else if (fill_acc)                           src = SRC_FILL;
    else                                         src = SRC_IDLE;
  end

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_be    = '0;
    ram_addr  = req_idx;
    ram_wdata = park_data;
    unique case (src)
      SRC_LOAD: begin
        ram_en = 1'b1;
      end
      SRC_PARK: begin
        ram_en   = 1'b1;
        ram_we   = 1'b1;
        ram_be   = park_be;
        ram_addr = park_idx;
      end
      SRC_FILL: begin
        ram_en    = 1'b1;
        ram_we    = 1'b1;
        ram_be    = {BYTES{1'b1}};
        ram_addr  = fill_idx;
        ram_wdata = fill_data;
      end
      default: ;
    endcase
  end

  csw_data_ram #(.DEPTH_W(INDEX_W), .DATA_W(DATA_W)) u_data (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .be    (ram_be),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  // Response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && lk_hit;
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign rsp_rdata[b*8 +: 8] = byp_mask[b] ? byp_data[b*8 +: 8] : ram_rdata[b*8 +: 8];
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2
  AST_NO_WRITE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_cyc |-> !ram_we); // R5
  AST_FILL_YIELDS: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !fill_ready); // R12
  AST_NO_STALE_PARK: assert property (@(posedge clk) disable iff (rst)
    drain |=> !park_valid); // R8
endmodule

// File: tb/test_csw_store_stage.sv
module test_csw_store_stage;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int INDEX_W = 4;
  localparam int BYTES = DATA_W / 8;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_store;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [BYTES-1:0]  req_be;
  logic rsp_valid, rsp_hit;
  logic [DATA_W-1:0] rsp_rdata;
  logic fill_valid;
  logic [ADDR_W-1:0] fill_addr;
  logic [DATA_W-1:0] fill_data;
  logic fill_ready;

  csw_store_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) i_csw_store_stage (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_ready(fill_ready)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference memory: tags 0..3, indexes 0..15, word aligned
  logic [DATA_W-1:0] ref_mem [64];

  function automatic logic [ADDR_W-1:0] mk_addr(int tag, int idx);
    return ADDR_W'((tag << 6) | (idx << 2));
  endfunction

  function automatic int key(logic [ADDR_W-1:0] a);
    return int'(a[7:2]);
  endfunction

  task automatic chk(bit ok, string rq, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // One request; returns the response sampled after the next edge
  task automatic op(bit st, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic [BYTES-1:0] be,
                    output bit hit, output logic [DATA_W-1:0] rd);
    req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R2 rsp_valid", DATA_W'(rsp_valid), 1);
    hit = rsp_hit;
    rd = rsp_rdata;
    req_valid = 1'b0;
    if (st && hit)
      for (int b = 0; b < BYTES; b++)
        if (be[b]) ref_mem[key(a)][b*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic do_fill(logic [ADDR_W-1:0] a, output int stalls);
    fill_valid = 1'b1; fill_addr = a; fill_data = ref_mem[key(a)];
    stalls = 0;
    #1;
    while (!fill_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic t_reset();
    bit h; logic [DATA_W-1:0] rd;
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", DATA_W'(rsp_valid), 0);
    chk(fill_ready === 1'b1, "R1 fill_ready idle", DATA_W'(fill_ready), 1);
    op(0, mk_addr(0, 0), '0, '0, h, rd);
    chk(h == 1'b0, "R1 load before fill misses", DATA_W'(h), 0);
  endtask

  task automatic t_miss_fill();
    bit h; logic [DATA_W-1:0] rd; int s;
    logic [ADDR_W-1:0] a = mk_addr(1, 3);
    op(0, a, '0, '0, h, rd);
    chk(h == 1'b0, "R9 load miss", DATA_W'(h), 0);
    do_fill(a, s);
    op(0, a, '0, '0, h, rd);
    chk(h == 1'b1, "R9 retry hits", DATA_W'(h), 1);
    chk(rd == ref_mem[key(a)], "R2 R9 fill data returned", rd, ref_mem[key(a)]);
  endtask

  task automatic t_bypass_partial();
    bit h; logic [DATA_W-1:0] rd; int s;
    logic [ADDR_W-1:0] a = mk_addr(0, 7);
    do_fill(a, s);
    op(1, a, 32'hDEAD_BEEF, 4'b0011, h, rd);
    chk(h == 1'b1, "R3 partial store hits", DATA_W'(h), 1);
    op(0, a, '0, '0, h, rd);
    chk(rd == ref_mem[key(a)], "R6 byte merge on bypass", rd, ref_mem[key(a)]);
  endtask

  task automatic t_deferred();
    bit h; logic [DATA_W-1:0] rd; int s;
    logic [ADDR_W-1:0] a = mk_addr(2, 1);
    logic [ADDR_W-1:0] b = mk_addr(2, 2);
    do_fill(a, s);
    do_fill(b, s);
    op(1, a, 32'h1111_2222, 4'hF, h, rd);
    op(1, b, 32'h3333_4444, 4'hF, h, rd);
    op(0, a, '0, '0, h, rd);
    chk(rd == 32'h1111_2222, "R5 first store reached array", rd, 32'h1111_2222);
    op(0, b, '0, '0, h, rd);
    chk(rd == 32'h3333_4444, "R3 parked store visible", rd, 32'h3333_4444);
  endtask

  task automatic t_miss_keeps();
    bit h; logic [DATA_W-1:0] rd;
    logic [ADDR_W-1:0] a = mk_addr(2, 1);
    op(1, a, 32'h5555_6666, 4'hF, h, rd);
    op(1, mk_addr(3, 9), 32'hFFFF_FFFF, 4'hF, h, rd);
    chk(h == 1'b0, "R4 store to unfilled line misses", DATA_W'(h), 0);
    op(0, a, '0, '0, h, rd);
    chk(rd == 32'h5555_6666, "R4 parked write survives miss", rd, 32'h5555_6666);
  endtask

  task automatic t_same_addr();
    bit h; logic [DATA_W-1:0] rd;
    logic [ADDR_W-1:0] a = mk_addr(2, 2);
    op(1, a, 32'hAAAA_0001, 4'hF, h, rd);
    op(1, a, 32'hBBBB_0002, 4'hF, h, rd);
    op(0, a, '0, '0, h, rd);
    chk(rd == 32'hBBBB_0002, "R10 second store wins", rd, 32'hBBBB_0002);
    op(1, mk_addr(2, 1), 32'h0, 4'h0, h, rd);
    op(0, a, '0, '0, h, rd);
    chk(rd == 32'hBBBB_0002, "R10 second store wins from array", rd, 32'hBBBB_0002);
  endtask

  task automatic t_alias_drain();
    bit h; logic [DATA_W-1:0] rd; int s;
    logic [ADDR_W-1:0] a = mk_addr(0, 5);
    logic [ADDR_W-1:0] c = mk_addr(1, 5);
    do_fill(a, s);
    op(1, a, 32'hCAFE_F00D, 4'hF, h, rd);
    op(0, c, '0, '0, h, rd);
    chk(h == 1'b0, "R7 alias tag misses", DATA_W'(h), 0);
    do_fill(c, s);
    chk(s == 1, "R8 one drain cycle", DATA_W'(s), 1);
    op(1, mk_addr(0, 7), 32'h0BAD_0BAD, 4'hF, h, rd);
    op(0, c, '0, '0, h, rd);
    chk(h == 1'b1 && rd == ref_mem[key(c)], "R8 filled word intact", rd, ref_mem[key(c)]);
    do_fill(a, s);
    op(0, a, '0, '0, h, rd);
    chk(rd == 32'hCAFE_F00D, "R8 drained data kept", rd, 32'hCAFE_F00D);
  endtask

  task automatic t_fill_blocked();
    req_valid = 1'b1; req_store = 1'b0; req_addr = mk_addr(0, 0);
    fill_valid = 1'b1; fill_addr = mk_addr(3, 15); fill_data = '0;
    #1;
    chk(fill_ready == 1'b0, "R12 fill blocked by request", DATA_W'(fill_ready), 0);
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
  endtask

  task automatic t_random();
    bit h; logic [DATA_W-1:0] rd; int s;
    for (int n = 0; n < 600; n++) begin
      logic [ADDR_W-1:0] a = mk_addr($urandom_range(0, 3), $urandom_range(0, 3) * 5);
      bit st = $urandom_range(0, 1) == 1;
      logic [DATA_W-1:0] d = $urandom;
      logic [BYTES-1:0] be = BYTES'($urandom_range(1, 15));
      op(st, a, d, be, h, rd);
      if (!h) begin
        do_fill(a, s);
        op(st, a, d, be, h, rd);
        chk(h == 1'b1, "R11 retry after fill hits", DATA_W'(h), 1);
      end
      if (!st && h) chk(rd == ref_mem[key(a)], "R11 load vs reference", rd, ref_mem[key(a)]);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 32'h7000_0000 + DATA_W'(i * 32'h0001_0203);
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    fill_valid = 1'b0; fill_addr = '0; fill_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_miss_fill();
    t_bypass_partial();
    t_deferred();
    t_miss_keeps();
    t_same_addr();
    t_alias_drain();
    t_fill_blocked();
    t_random();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule